// File: doc/BRIEF.md
# Real-Time-Clock Alarm and Run-Control Registers

This block is the register front end of a real-time-clock peripheral. It holds a set of alarm compare registers, each carrying a compare value and its own enable bit. It watches the current time fields supplied by the counting chain and raises an alarm flag when all the enabled fields agree with the time. An alarm control register holds that flag and an alarm interrupt enable. A second control register carries a periodic interrupt flag, a period select, a clock enable, an adjust strobe, a divider reset strobe and a start bit.

Software reads and writes bytes over a simple register bus, using an address, a write strobe, write data and combinational read data. The counting chain receives the clock enable, start, period select and the two strobes. A periodic tick from the divider sets the periodic flag. There are three reset conditions with different reach. Power-on reset clears everything. Manual reset reinitializes the second control register but leaves the run-control bits as they are. The standby input freezes that register completely.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: Alarm register k (address k, for k from 0 to NUM_FIELDS-1) holds an enable in bit 7 and a compare value in bits 6:0, checked against time field k at `cur_time[k*7 +: 7]`. The alarm flag sets in the cycle after the first cycle in which all enabled fields match. It does not set again while the match persists, and it never sets when no field is enabled.
- R2: The alarm control register is at address NUM_FIELDS, with the flag in bit 0 and the interrupt enable in bit 3. Writing it with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged.
- R3: `alarm_irq` is high exactly while both the alarm flag and the alarm interrupt enable are 1. The interrupt enable resets to 0.
- R4: Control register 2 is at address NUM_FIELDS+1. Its layout is bit 7 periodic flag, bits 6:4 period select, bit 3 clock enable, bit 2 adjust, bit 1 divider reset, bit 0 start. Written select, clock-enable and start values read back and appear on `period_sel`, `clk_en` and `start`.
- R5: Power-on reset (`por_n` low, asynchronous) loads control register 2 with 0x09. It clears the alarm registers, the alarm flag and the interrupt enable.
- R6: Manual reset (`man_rst` high at a clock edge, standby low) clears the periodic flag, the period select and both strobes. It keeps the clock enable and start bits.
- R7: While `standby` is high, control register 2 holds every bit. Register writes, manual reset and ticks have no effect on it, and no strobe is issued.
- R8: A `tick` while the period select is nonzero sets the periodic flag. A select of 000 blocks the tick. Writing bit 7 = 0 clears the flag, and writing bit 7 = 1 leaves it unchanged. `periodic_irq` equals the flag.
- R9: When a set event (an alarm match edge or a qualifying tick) and a software write of 0 to the same flag fall in one cycle, the flag ends up set.
- R10: Writing 1 to bit 2 or bit 1 of control register 2 gives a one-cycle high on `adj_pulse` or `div_rst_pulse` in the cycle after the write. Both bits always read back as 0.
- R11: Reads are combinational. Alarm registers return the full stored byte, and addresses beyond NUM_FIELDS+1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| standby | input | 1 | Standby: freezes control register 2 |
| tick | input | 1 | Periodic tick from the divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cur_time | input | NUM_FIELDS*7 | Current time fields, field k at bits k*7 +: 7 |
| alarm_irq | output | 1 | Alarm interrupt request |
| periodic_irq | output | 1 | Periodic interrupt request |
| clk_en | output | 1 | Clock enable bit |
| start | output | 1 | Start bit |
| period_sel | output | 3 | Period select field |
| adj_pulse | output | 1 | One-cycle adjust strobe |
| div_rst_pulse | output | 1 | One-cycle divider reset strobe |

## Verification
The assertions check several rules on every cycle. An alarm flag rise must follow a cycle with a match, and the flag may only fall after a write of 0. A qualifying tick must leave the periodic request high. Standby must freeze the run-control outputs, and manual reset must keep clock enable and start. An adjust strobe must trace back to an accepted write. The bench scenarios cover the rest: the edge-only behaviour of the alarm under a held match, the case with no enabled field, set-over-clear collisions at both flags, read-back layouts, and the power-on value after a mid-run reset.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

    localparam int DATA_W   = 8;
    localparam int VAL_W    = DATA_W - 1;
    localparam int EN_BIT   = DATA_W - 1;

    // alarm control register bit positions
    localparam int AIE_BIT  = 3;
    localparam int AF_BIT   = 0;

    // control register 2 bit positions
    localparam int PF_BIT   = 7;
    localparam int PS_LSB   = 4;
    localparam int PS_W     = 3;
    localparam int CE_BIT   = 3;
    localparam int ADJ_BIT  = 2;
    localparam int DR_BIT   = 1;
    localparam int ST_BIT   = 0;

    localparam logic [DATA_W-1:0] CTL2_POR = 8'h09;

    // field order matches the register bit order, MSB first
    typedef struct packed {
        logic            pflag;
        logic [PS_W-1:0] psel;
        logic            clk_en;
        logic            adj;
        logic            div_rst;
        logic            start;
    } ctl2_t;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_regs_pkg::*;
#(
    parameter int NUM_FIELDS = 7
) (
    input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_regs,
    input  logic [NUM_FIELDS*VAL_W-1:0]       cur_time,
    output logic                              any_en,
    output logic                              match
);

    logic [NUM_FIELDS-1:0] en_v;
    logic [NUM_FIELDS-1:0] hit_v;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign en_v[g]  = alm_regs[g][EN_BIT];
        // a disabled field always counts as a hit
        assign hit_v[g] = !en_v[g] ||
                          (alm_regs[g][VAL_W-1:0] == cur_time[g*VAL_W +: VAL_W]);
    end

    assign any_en = |en_v;
    assign match  = any_en && (&hit_v);

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_regs_pkg::*;
#(
    parameter int NUM_FIELDS = 7
) (
    input  logic                              clk,
    input  logic                              por_n,
    input  logic [NUM_FIELDS-1:0]             fld_we,
    input  logic                              ctl_we,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              match,
    output logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_regs,
    output logic                              aie,
    output logic                              af
);

    typedef struct packed {
        logic [NUM_FIELDS-1:0][DATA_W-1:0] fld;
        logic                              aie;
        logic                              af;
        logic                              mprev;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic       set_ev;

    always_comb begin
        st_d   = st_q;
        set_ev = match && !st_q.mprev;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (fld_we[i]) begin
                st_d.fld[i] = wdata;
            end
        end
        st_d.mprev = match;
        if (ctl_we) begin
            st_d.aie = wdata[AIE_BIT];
            if (!wdata[AF_BIT]) begin
                st_d.af = 1'b0;
            end
        end
        // hardware set has priority over a software clear
        if (set_ev) begin
            st_d.af = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alm_regs = st_q.fld;
    assign aie      = st_q.aie;
    assign af       = st_q.af;

endmodule

// File: rtl/rtc_ctl2_regs.sv
module rtc_ctl2_regs
    import rtc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst,
    input  logic              standby,
    input  logic              tick,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctl2_t             ctl_q
);

    ctl2_t ctl_d;
    logic  tick_set;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.adj     = 1'b0;
        ctl_d.div_rst = 1'b0;
        tick_set      = tick && (ctl_q.psel != '0);
        if (standby) begin
            // every stored bit frozen, no strobes
            ctl_d.adj     = 1'b0;
        end else if (man_rst) begin
            ctl_d.pflag   = 1'b0;
            ctl_d.psel    = '0;
        end else begin
            if (we) begin
                ctl_d.psel    = wdata[PS_LSB +: PS_W];
                ctl_d.clk_en  = wdata[CE_BIT];
                ctl_d.start   = wdata[ST_BIT];
                ctl_d.adj     = wdata[ADJ_BIT];
                ctl_d.div_rst = wdata[DR_BIT];
                if (!wdata[PF_BIT]) begin
                    ctl_d.pflag = 1'b0;
                end
            end
            if (tick_set) begin
                ctl_d.pflag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= ctl2_t'(CTL2_POR);
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
    import rtc_regs_pkg::*;
#(
    parameter int NUM_FIELDS = 7,
    parameter int ADDR_W     = 4
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        man_rst,
    input  logic                        standby,
    input  logic                        tick,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    input  logic [NUM_FIELDS*7-1:0]     cur_time,
    output logic                        alarm_irq,
    output logic                        periodic_irq,
    output logic                        clk_en,
    output logic                        start,
    output logic [2:0]                  period_sel,
    output logic                        adj_pulse,
    output logic                        div_rst_pulse
);

    localparam logic [ADDR_W-1:0] ACTL_ADDR = ADDR_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] CTL2_ADDR = ADDR_W'(NUM_FIELDS + 1);

    logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_regs;
    logic [NUM_FIELDS-1:0]             fld_we;
    logic                              actl_we;
    logic                              ctl2_we;
    logic                              alm_match;
    logic                              alm_any_en;
    logic                              alm_aie;
    logic                              alm_af;
    ctl2_t                             ctl2_q;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_we
        assign fld_we[g] = wr_en && (addr == ADDR_W'(g));
    end
    assign actl_we = wr_en && (addr == ACTL_ADDR);
    assign ctl2_we = wr_en && (addr == CTL2_ADDR);

    rtc_alarm_cmp #(
        .NUM_FIELDS (NUM_FIELDS)
    ) u_cmp (
        .alm_regs (alm_regs),
        .cur_time (cur_time),
        .any_en   (alm_any_en),
        .match    (alm_match)
    );

    rtc_alarm_regs #(
        .NUM_FIELDS (NUM_FIELDS)
    ) u_alm (
        .clk      (clk),
        .por_n    (por_n),
        .fld_we   (fld_we),
        .ctl_we   (actl_we),
        .wdata    (wdata),
        .match    (alm_match),
        .alm_regs (alm_regs),
        .aie      (alm_aie),
        .af       (alm_af)
    );

    rtc_ctl2_regs u_ctl2 (
        .clk     (clk),
        .por_n   (por_n),
        .man_rst (man_rst),
        .standby (standby),
        .tick    (tick),
        .we      (ctl2_we),
        .wdata   (wdata),
        .ctl_q   (ctl2_q)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = alm_regs[i];
            end
        end
        if (addr == ACTL_ADDR) begin
            rdata[AIE_BIT] = alm_aie;
            rdata[AF_BIT]  = alm_af;
        end
        if (addr == CTL2_ADDR) begin
            rdata          = ctl2_q;
            rdata[ADJ_BIT] = 1'b0;
            rdata[DR_BIT]  = 1'b0;
        end
    end

    assign alarm_irq     = alm_af && alm_aie;
    assign periodic_irq  = ctl2_q.pflag;
    assign clk_en        = ctl2_q.clk_en;
    assign start         = ctl2_q.start;
    assign period_sel    = ctl2_q.psel;
    assign adj_pulse     = ctl2_q.adj;
    assign div_rst_pulse = ctl2_q.div_rst;

endmodule

// File: rtl/rtc_alarm_ctl_chk.sv
module rtc_alarm_ctl_chk #(
    parameter int NUM_FIELDS = 7,
    parameter int ADDR_W     = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              man_rst,
    input logic              standby,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              periodic_irq,
    input logic              clk_en,
    input logic              start,
    input logic [2:0]        period_sel,
    input logic              adj_pulse,
    input logic              alm_af,
    input logic              alm_match
);

    localparam logic [ADDR_W-1:0] A_ACTL = ADDR_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(NUM_FIELDS + 1);

    AST_ALARM_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(alm_af) |-> $past(alm_match)); // R1

    AST_ALARM_FALL_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        $fell(alm_af) |-> $past(wr_en && addr == A_ACTL && !wdata[0])); // R2

    AST_TICK_RAISES_PIRQ: assert property (@(posedge clk) disable iff (!por_n)
        (tick && period_sel != 3'd0 && !standby && !man_rst) |=> periodic_irq); // R8

    AST_PIRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(periodic_irq) |-> $past((wr_en && addr == A_CTL2 && !wdata[7]) || man_rst)); // R8

    AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
        standby |=> $stable({periodic_irq, period_sel, clk_en, start})); // R7

    AST_MANRST_KEEPS_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (man_rst && !standby) |=> ($stable({clk_en, start}) && !periodic_irq && period_sel == 3'd0)); // R6

    AST_ADJ_FROM_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        adj_pulse |-> $past(wr_en && addr == A_CTL2 && wdata[2] && !standby && !man_rst)); // R10

endmodule

bind rtc_alarm_ctl rtc_alarm_ctl_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .man_rst      (man_rst),
    .standby      (standby),
    .tick         (tick),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .periodic_irq (periodic_irq),
    .clk_en       (clk_en),
    .start        (start),
    .period_sel   (period_sel),
    .adj_pulse    (adj_pulse),
    .alm_af       (alm_af),
    .alm_match    (alm_match)
);

// File: tb/sim_rtc_alarm_ctl.sv
`timescale 1ns/1ps
module sim_rtc_alarm_ctl;

    localparam int NF = 7;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        man_rst = 1'b0;
    logic        standby = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [NF*7-1:0] cur_time = '0;
    logic        alarm_irq, periodic_irq, clk_en, start, adj_pulse, div_rst_pulse;
    logic [2:0]  period_sel;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rtc_alarm_ctl u0 (
        .clk(clk), .por_n(por_n), .man_rst(man_rst), .standby(standby), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .cur_time(cur_time),
        .alarm_irq(alarm_irq), .periodic_irq(periodic_irq), .clk_en(clk_en), .start(start),
        .period_sel(period_sel), .adj_pulse(adj_pulse), .div_rst_pulse(div_rst_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_alm [NF];
    logic m_aie, m_af, m_mprev, m_pf, m_ce, m_st, m_adj, m_dr, m_ok;
    logic [2:0] m_ps;

    function automatic logic [7:0] m_rd(input logic [3:0] a);
        if (int'(a) < NF) return m_alm[a];
        if (int'(a) == NF) return {4'b0, m_aie, 2'b0, m_af};
        if (int'(a) == NF + 1) return {m_pf, m_ps, m_ce, 2'b00, m_st};
        return 8'h00;
    endfunction

    always @(posedge clk) begin : model
        logic any, ok, mt, tset;
        if (!por_n) begin
            for (int i = 0; i < NF; i++) m_alm[i] = 8'h00;
            m_aie = 0; m_af = 0; m_mprev = 0;
            m_pf = 0; m_ps = 0; m_ce = 1; m_st = 1; m_adj = 0; m_dr = 0;
            m_ok = 1;
        end else begin
            any = 0; ok = 1;
            for (int i = 0; i < NF; i++) begin
                if (m_alm[i][7]) begin
                    any = 1;
                    if (m_alm[i][6:0] != cur_time[i*7 +: 7]) ok = 0;
                end
            end
            mt = any && ok;
            if (wr_en && int'(addr) == NF) begin
                m_aie = wdata[3];
                if (!wdata[0]) m_af = 0;
            end
            if (mt && !m_mprev) m_af = 1;
            m_mprev = mt;
            if (wr_en && int'(addr) < NF) m_alm[addr] = wdata;
            m_adj = 0; m_dr = 0;
            if (!standby) begin
                if (man_rst) begin
                    m_pf = 0; m_ps = 0;
                end else begin
                    tset = tick && (m_ps != 0);
                    if (wr_en && int'(addr) == NF + 1) begin
                        m_ps = wdata[6:4]; m_ce = wdata[3]; m_st = wdata[0];
                        m_adj = wdata[2]; m_dr = wdata[1];
                        if (!wdata[7]) m_pf = 0;
                    end
                    if (tset) m_pf = 1;
                end
            end
        end
    end

    initial m_ok = 0;

    always @(negedge clk) begin
        if (por_n && m_ok) begin
            check("R3 alarm_irq", 32'(alarm_irq), 32'(m_af && m_aie));
            check("R8 periodic_irq", 32'(periodic_irq), 32'(m_pf));
            check("R4 run outputs", {27'd0, period_sel, clk_en, start}, {27'd0, m_ps, m_ce, m_st});
            check("R10 strobes", {30'd0, adj_pulse, div_rst_pulse}, {30'd0, m_adj, m_dr});
            check("R11 rdata", 32'(rdata), 32'(m_rd(addr)));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a;
        #1 check(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic pulse_tick();
        @(negedge clk); #1 tick = 1;
        @(posedge clk); #1 tick = 0;
    endtask

    task automatic set_fld(input int k, input logic [6:0] v);
        @(negedge clk); #1 cur_time[k*7 +: 7] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk); #1 por_n = 1;
        // R5 reset state
        rd(4'd8, 8'h09, "R5 ctl2 por value");
        rd(4'd7, 8'h00, "R5 alarm ctl por value R3");
        check("R3 irq low after reset", 32'(alarm_irq), 0);

        // R11 / R1 alarm fields
        wr(4'd0, 8'h85); wr(4'd1, 8'h8A); wr(4'd2, 8'h15);
        set_fld(0, 7'd5); set_fld(1, 7'd3); set_fld(2, 7'h40);
        rd(4'd0, 8'h85, "R11 alarm reg 0");
        rd(4'd2, 8'h15, "R11 alarm reg 2");
        idle(2);
        rd(4'd7, 8'h00, "R1 no match yet");
        set_fld(1, 7'd10);
        idle(1);
        rd(4'd7, 8'h01, "R1 match sets flag, disabled field ignored");
        wr(4'd7, 8'h00);
        idle(3);
        rd(4'd7, 8'h00, "R1 held match does not set again");
        set_fld(1, 7'd3); idle(1);
        set_fld(1, 7'd10); idle(1);
        wr(4'd7, 8'h09);
        rd(4'd7, 8'h09, "R2 write 1 keeps flag");
        check("R3 irq with flag and enable", 32'(alarm_irq), 1);
        wr(4'd7, 8'h08);
        rd(4'd7, 8'h08, "R2 write 0 clears flag");
        check("R3 irq low without flag", 32'(alarm_irq), 0);
        // R9 alarm set beats clear
        set_fld(1, 7'd3); idle(1);
        @(negedge clk); #1;
        cur_time[1*7 +: 7] = 7'd10;
        idle(1);
        @(negedge clk); #1;
        wr_en = 1; addr = 4'd7; wdata = 8'h08;
        cur_time[1*7 +: 7] = 7'd3;
        @(posedge clk); #1 wr_en = 0;
        @(negedge clk); #1 cur_time[1*7 +: 7] = 7'd10; wr_en = 1; addr = 4'd7; wdata = 8'h08;
        @(posedge clk); #1 wr_en = 0;
        rd(4'd7, 8'h09, "R9 alarm set wins over clear");
        // R1 no enabled field
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h00); wr(4'd7, 8'h08);
        set_fld(1, 7'd3); idle(1); set_fld(1, 7'd10); idle(2);
        rd(4'd7, 8'h08, "R1 no enabled field never sets");

        // R4 control register 2
        wr(4'd8, 8'h31);
        rd(4'd8, 8'h31, "R4 ctl2 readback");
        check("R4 period_sel", 32'(period_sel), 3);
        check("R4 clk_en", 32'(clk_en), 0);
        wr(4'd8, 8'h35);
        check("R10 adjust strobe high", 32'(adj_pulse), 1);
        idle(1);
        check("R10 adjust strobe one cycle", 32'(adj_pulse), 0);
        rd(4'd8, 8'h31, "R10 adjust reads 0");
        wr(4'd8, 8'h33);
        check("R10 divider strobe high", 32'(div_rst_pulse), 1);
        rd(4'd8, 8'h31, "R10 divider reads 0");

        // R8 periodic flag
        pulse_tick();
        rd(4'd8, 8'hB1, "R8 tick sets flag");
        check("R8 periodic irq", 32'(periodic_irq), 1);
        wr(4'd8, 8'hB1);
        rd(4'd8, 8'hB1, "R8 write 1 keeps flag");
        wr(4'd8, 8'h31);
        rd(4'd8, 8'h31, "R8 write 0 clears flag");
        wr(4'd8, 8'h01);
        pulse_tick();
        rd(4'd8, 8'h01, "R8 select 000 blocks tick");
        wr(4'd8, 8'h31);
        pulse_tick();
        @(negedge clk); #1;
        tick = 1; wr_en = 1; addr = 4'd8; wdata = 8'h31;
        @(posedge clk); #1 tick = 0; wr_en = 0;
        rd(4'd8, 8'hB1, "R9 tick set wins over clear");

        // R6 manual reset
        wr(4'd8, 8'h38);
        pulse_tick();
        rd(4'd8, 8'hB8, "R6 setup");
        @(negedge clk); #1 man_rst = 1;
        @(posedge clk); #1 man_rst = 0;
        rd(4'd8, 8'h08, "R6 manual reset keeps run bits");

        // R7 standby
        wr(4'd8, 8'h39);
        pulse_tick();
        @(negedge clk); #1 standby = 1;
        wr(4'd8, 8'h04);
        check("R7 no strobe in standby", 32'(adj_pulse), 0);
        @(negedge clk); #1 man_rst = 1;
        @(posedge clk); #1 man_rst = 0;
        pulse_tick();
        rd(4'd8, 8'hB9, "R7 standby holds ctl2");
        @(negedge clk); #1 standby = 0;

        // R11 unused address
        rd(4'hF, 8'h00, "R11 unused address reads 0");

        // R5 power-on reset mid-run
        wr(4'd3, 8'h9F);
        @(negedge clk); #1 por_n = 0;
        idle(2);
        @(negedge clk); #1 por_n = 1;
        rd(4'd8, 8'h09, "R5 ctl2 after power-on reset");
        rd(4'd3, 8'h00, "R5 alarm reg cleared");
        rd(4'd7, 8'h00, "R5 alarm ctl cleared");

        idle(2);
        finish_run();
    end

endmodule